// File: doc/BRIEF.md
# Four-State Mealy Test Machine

This block is a small synchronous Mealy machine with four states, a single-bit input and a single-bit output. The output is a combinational function of the present state and the current input. The two state bits are also driven out, so the state can be observed directly at the pins.

A synchronous preload port forces the machine into any of its four states on a chosen clock edge. A test environment uses it to start the same input stream from each possible starting state and then compare the output streams against the expected ones. An asynchronous active-low reset places the machine in its home state.

State names and their codes on the pins (`st_hi`, `st_lo`) are: HOME=00, WAIT=01, PEAK=11, EDGE=10.

Top module: `mealy_probe_fsm`

## Requirements
- R1: The state code appears on `st_hi`/`st_lo` as HOME=00, WAIT=01, PEAK=11, EDGE=10, with `st_hi` as the high bit.
- R2: While `rst_n` is low, the state is HOME (00) at once, without waiting for a clock edge.
- R3: From HOME, `din`=0 keeps HOME with `z_out`=0, and `din`=1 moves to EDGE with `z_out`=0.
- R4: From WAIT, either value of `din` moves to PEAK with `z_out`=1.
- R5: From PEAK, `din`=0 moves to WAIT with `z_out`=1, and `din`=1 moves to HOME with `z_out`=0.
- R6: From EDGE, `din`=0 moves to HOME with `z_out`=1, and `din`=1 moves to WAIT with `z_out`=1.
- R7: `z_out` follows a change on `din` within the same cycle, with no clock edge needed.
- R8: When `pre_en` is high at a rising edge, the state becomes `pre_state` and the table is ignored for that edge. `z_out` in that cycle still reflects the present state and `din`.
- R9: The input stream 1,0,1,1,1 gives these outputs: 0,1,0,1,1 from HOME (ending in PEAK), 1,1,1,0,0 from WAIT (ending in EDGE), 0,0,0,1,1 from PEAK (ending in PEAK), and 1,1,0,0,1 from EDGE (ending in WAIT).
- R10: With `pre_en` low, the state changes only at a rising edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset to HOME |
| din | input | 1 | Serial input bit |
| pre_en | input | 1 | Synchronous preload enable |
| pre_state | input | 2 | State code loaded when `pre_en` is high |
| z_out | output | 1 | Mealy output from present state and `din` |
| st_hi | output | 1 | High state bit |
| st_lo | output | 1 | Low state bit |

## Verification
The clocked assertions assume that `din`, `pre_en` and `pre_state` are stable around the rising edge, so the sampled values match the values that set the next state. The bench only changes these inputs on the falling edge, or in the middle of the low phase for the `din` toggle checks. The assertions also assume that reset is released away from a clock edge. The bench releases it on a falling edge.

// File: rtl/mealy_probe_pkg.sv
package mealy_probe_pkg;
  localparam int STW = 2;

  typedef enum logic [STW-1:0] {
    S_HOME = 2'b00,
    S_WAIT = 2'b01,
    S_EDGE = 2'b10,
    S_PEAK = 2'b11
  } state_e;

  // Next-state function of the table.
  function automatic state_e step_state(state_e s, logic x);
    case (s)
      S_HOME:  return x ? S_EDGE : S_HOME;
      S_WAIT:  return S_PEAK;
      S_PEAK:  return x ? S_HOME : S_WAIT;
      default: return x ? S_WAIT : S_HOME;
    endcase
  endfunction

  // Mealy output function of the table.
  function automatic logic step_out(state_e s, logic x);
    case (s)
      S_HOME:  return 1'b0;
      S_WAIT:  return 1'b1;
      S_PEAK:  return ~x;
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/mealy_probe_comb.sv
module mealy_probe_comb
  import mealy_probe_pkg::*;
(
  input  state_e cur_st,
  input  logic   x_in,
  output state_e nxt_st,
  output logic   z
);
  always_comb begin
    nxt_st = step_state(cur_st, x_in);
    z      = step_out(cur_st, x_in);
  end
endmodule

// File: rtl/mealy_probe_streg.sv
module mealy_probe_streg
  import mealy_probe_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld,
  input  logic [STW-1:0] ld_val,
  input  state_e         nxt_st,
  output state_e         q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= S_HOME;
    else if (ld) q <= state_e'(ld_val);
    else         q <= nxt_st;
  end

  // R8: a preload takes the loaded value at the edge
  a_r8_preload_taken: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (q == $past(ld_val)));

  // R10: no preload and an unchanged table target leaves the state stable
  a_r10_hold_when_same: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && nxt_st == q) |=> $stable(q));
endmodule

// File: rtl/mealy_probe_fsm.sv
module mealy_probe_fsm
  import mealy_probe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic       pre_en,
  input  logic [1:0] pre_state,
  output logic       z_out,
  output logic       st_hi,
  output logic       st_lo
);
  state_e cur_st;
  state_e nxt_st;
  logic   z_int;

  mealy_probe_comb u_comb (
    .cur_st (cur_st),
    .x_in   (din),
    .nxt_st (nxt_st),
    .z      (z_int)
  );

  mealy_probe_streg u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (pre_en),
    .ld_val (pre_state),
    .nxt_st (nxt_st),
    .q      (cur_st)
  );

  assign z_out = z_int;
  assign st_hi = cur_st[1];
  assign st_lo = cur_st[0];

  // R2: reset holds the machine in HOME
  a_r2_reset_home: assert property (@(posedge clk)
    !rst_n |-> (cur_st == S_HOME));

  // R3: HOME with 0 stays in HOME
  a_r3_home_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_en && cur_st == S_HOME && !din) |=> (cur_st == S_HOME));

  // R4: WAIT always moves to PEAK and outputs 1
  a_r4_wait_to_peak: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_en && cur_st == S_WAIT) |=> (cur_st == S_PEAK));
  a_r4_wait_out: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_st == S_WAIT) |-> z_out);

  // R5: PEAK with 1 returns to HOME
  a_r5_peak_home: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_en && cur_st == S_PEAK && din) |=> (cur_st == S_HOME));

  // R6: EDGE always leaves and outputs 1
  a_r6_edge_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_en && cur_st == S_EDGE) |=> (cur_st != S_EDGE));
  a_r6_edge_out: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_st == S_EDGE) |-> z_out);
endmodule

// File: tb/mealy_probe_fsm_tb.sv
`timescale 1ns/1ps
module mealy_probe_fsm_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       din = 1'b0;
  logic       pre_en = 1'b0;
  logic [1:0] pre_state = 2'b00;
  logic       z_out, st_hi, st_lo;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mealy_probe_fsm dut_i (
    .clk(clk), .rst_n(rst_n), .din(din), .pre_en(pre_en),
    .pre_state(pre_state), .z_out(z_out), .st_hi(st_hi), .st_lo(st_lo)
  );

  // Single-step table, entry format {state, x, z, next}
  localparam logic [5:0] STEP_TAB [8] = '{
    6'b00_0_0_00, 6'b00_1_0_10, 6'b01_0_1_11, 6'b01_1_1_11,
    6'b11_0_1_01, 6'b11_1_0_00, 6'b10_0_1_00, 6'b10_1_1_01
  };
  // Stream table (R9), entry format {start, x[4:0] msb first, z[4:0], end}
  localparam logic [13:0] SEQ_TAB [4] = '{
    14'b00_10111_01011_11, 14'b01_10111_11100_10,
    14'b11_10111_00011_11, 14'b10_10111_11001_01
  };

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic preload(input logic [1:0] s);
    @(negedge clk); pre_en = 1'b1; pre_state = s;
    @(negedge clk); pre_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #12;
    chk("R2 reset state", {st_hi, st_lo}, 2'b00);
    @(negedge clk); rst_n = 1'b1;
    chk("R1 home code", {st_hi, st_lo}, 2'b00);

    // R3 R4 R5 R6: every table step
    for (int i = 0; i < 8; i++) begin
      preload(STEP_TAB[i][5:4]);
      chk("R1 loaded code", {st_hi, st_lo}, STEP_TAB[i][5:4]);
      din = STEP_TAB[i][3];
      #1 chk("R3-6 step out", {1'b0, z_out}, {1'b0, STEP_TAB[i][2]});
      @(negedge clk);
      chk("R3-6 step next", {st_hi, st_lo}, STEP_TAB[i][1:0]);
    end

    // R9: the five-bit stream from each start state
    for (int k = 0; k < 4; k++) begin
      preload(SEQ_TAB[k][13:12]);
      for (int b = 4; b >= 0; b--) begin
        din = SEQ_TAB[k][7 + b];
        #1 chk("R9 stream out", {1'b0, z_out}, {1'b0, SEQ_TAB[k][2 + b]});
        @(negedge clk);
      end
      chk("R9 stream end", {st_hi, st_lo}, SEQ_TAB[k][1:0]);
    end

    // R7: output follows din with no clock edge (PEAK: 0->1, 1->0)
    preload(2'b11);
    din = 1'b0; #1 chk("R7 din low", {1'b0, z_out}, 2'b01);
    din = 1'b1; #1 chk("R7 din high", {1'b0, z_out}, 2'b00);
    din = 1'b0; #1 chk("R7 din low again", {1'b0, z_out}, 2'b01);
    chk("R10 no edge no move", {st_hi, st_lo}, 2'b11);

    // R8: preload overrides table, output still from present state
    preload(2'b01);
    pre_en = 1'b1; pre_state = 2'b00; din = 1'b1;
    #1 chk("R8 out during load", {1'b0, z_out}, 2'b01);
    @(negedge clk); pre_en = 1'b0;
    chk("R8 override", {st_hi, st_lo}, 2'b00);

    // R2: asynchronous reset mid-cycle
    preload(2'b10);
    #2 rst_n = 1'b0;
    #1 chk("R2 async reset", {st_hi, st_lo}, 2'b00);
    @(negedge clk); rst_n = 1'b1;
    chk("R2 after release", {st_hi, st_lo}, 2'b00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule